// File: doc/BRIEF.md
# Two-Port Accumulator Processor Controller

This block is a compact multicycle processor driven by a control state machine. Program and data live in two separate synchronous memories outside the block. The program memory is 8 bits wide, so each 16-bit instruction is read as two bytes. The data memory is 16 bits wide. The datapath holds a program counter, an instruction register, a 16-bit accumulator and a small ALU that flags negative and zero results.

After reset the controller clears the machine. It then repeats fetch, decode and an execute sequence. The execute sequence differs for memory transfers, accumulator arithmetic and control-flow instructions. A halt instruction parks the controller and raises an output, so surrounding logic or a testbench can inspect the data memory afterwards.

Both memories are expected to return read data on the clock edge after the read strobe. Instruction layout: bits 15:12 hold the opcode, and bits 11:0 hold an operand that is zero-extended to 16 bits.

Top module: `acc_core`

## Requirements
- R1: While reset is high and after it is released, the program counter, accumulator and both flags are zero. All strobes and `halted` are low during reset. The first instruction read uses address 0.
- R2: Each instruction is fetched as two byte reads, at PC and then at PC+1. The first byte is bits 15:8 of the instruction.
- R3: Opcode map: 0 NOP, 1 LOAD, 2 STORE, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 branch-if-zero, 8 branch-if-negative, 9 jump, F halt.
- R4: LOAD reads data memory at the operand address and places the word in the accumulator.
- R5: ADD, SUB, AND and OR combine the accumulator with the data word at the operand address. SUB computes accumulator minus operand. Results wrap modulo 2^16.
- R6: STORE writes the accumulator to the operand address using a one-cycle write strobe. Data reads and writes are never strobed together. STORE leaves the accumulator unchanged.
- R7: A conditional branch is taken when its flag is set, and a jump is always taken. A taken branch loads PC with the operand. Otherwise PC advances by 2.
- R8: N (result bit 15) and Z (result equal to zero) change only on LOAD and ALU instructions. STORE and branches leave them unchanged.
- R9: HALT raises `halted` until reset and issues no further strobes. While halted, `imemAddr` shows the HALT instruction's address.
- R10: NOP and the unassigned opcodes A to E only advance PC by 2.
- R11: Each instruction takes a fixed number of cycles. NOP, STORE and branches take 4. LOAD and ALU instructions take 5. HALT reaches the halted state 3 cycles after its first fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemRd | output | 1 | Program memory read strobe |
| imemAddr | output | 16 | Program memory byte address |
| imemRdata | input | 8 | Program byte, valid the cycle after imemRd |
| dmemRd | output | 1 | Data memory read strobe |
| dmemWr | output | 1 | Data memory write strobe |
| dmemAddr | output | 16 | Data memory word address |
| dmemWdata | output | 16 | Data written on dmemWr |
| dmemRdata | input | 16 | Data word, valid the cycle after dmemRd |
| halted | output | 1 | High while parked after HALT |

## Verification
Several properties are checked on every cycle:
- the halt state is sticky and quiet;
- the write strobe lasts one cycle, and data reads and writes are exclusive;
- decode always follows the second byte fetch;
- PC, the flags and the accumulator hold their values when no strobe permits a change.

The arithmetic results, the flag values and the taken or not-taken path of each branch can only be shown by running programs. The same applies to the per-class cycle counts and to the fetch byte order. The bench's programs expose these through the final data memory contents, the address where the processor halts, and the cycle count to halt.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 4'h0,
    OPC_LOAD  = 4'h1,
    OPC_STORE = 4'h2,
    OPC_ADD   = 4'h3,
    OPC_SUB   = 4'h4,
    OPC_AND   = 4'h5,
    OPC_OR    = 4'h6,
    OPC_BRZ   = 4'h7,
    OPC_BRN   = 4'h8,
    OPC_JMP   = 4'h9,
    OPC_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR
  } alu_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    clr;
    logic    imemRd;
    logic    fetchLo;
    logic    irHiLd;
    logic    irLoLd;
    logic    pcInc;
    logic    pcLd;
    logic    dmemRd;
    logic    dmemWr;
    logic    accLd;
    alu_op_e aluOp;
  } ctrl_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic             flagN;
    logic             flagZ;
  } status_t;

endpackage

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_core_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int IBYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic [IBYTE_W-1:0] imemRdata,
  input  logic [DATA_W-1:0]  dmemRdata,
  output logic [ADDR_W-1:0]  imemAddr,
  output logic [ADDR_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWdata,
  output status_t            stat
);

  localparam int INSTR_W = 2 * IBYTE_W;
  localparam int OPND_W  = INSTR_W - OPC_W;

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  acc;
  logic               flagN, flagZ;
  logic [DATA_W-1:0]  aluRes;
  logic [ADDR_W-1:0]  operand;

  assign operand   = ADDR_W'(ir[OPND_W-1:0]);
  assign imemAddr  = pc + ADDR_W'(ctrl.fetchLo);
  assign dmemAddr  = operand;
  assign dmemWdata = acc;
  assign stat      = '{opcode: ir[INSTR_W-1 -: OPC_W], flagN: flagN, flagZ: flagZ};

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_ADD: aluRes = acc + dmemRdata;
      ALU_SUB: aluRes = acc - dmemRdata;
      ALU_AND: aluRes = acc & dmemRdata;
      ALU_OR:  aluRes = acc | dmemRdata;
      default: aluRes = dmemRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clr) begin
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
    end else begin
      if (ctrl.pcLd)       pc <= operand;
      else if (ctrl.pcInc) pc <= pc + ADDR_W'(2);
      if (ctrl.irHiLd) ir[INSTR_W-1:IBYTE_W] <= imemRdata;
      if (ctrl.irLoLd) ir[IBYTE_W-1:0]       <= imemRdata;
      if (ctrl.accLd) begin
        acc   <= aluRes;
        flagN <= aluRes[DATA_W-1];
        flagZ <= (aluRes == '0);
      end
    end
  end

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.accLd && !ctrl.clr) |=> $stable({flagN, flagZ}));

  p_acc_store_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.dmemWr |=> $stable(acc));

  p_pc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pcLd && !ctrl.pcInc && !ctrl.clr) |=> $stable(pc));

endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_core_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  status_t stat,
  output ctrl_t   ctrl,
  output logic    halted
);

  typedef enum logic [3:0] {
    S_INIT, S_FETCH1, S_FETCH2, S_DECODE, S_DRD, S_DEXEC,
    S_DWR, S_TAKEN, S_ADVANCE, S_HALT
  } state_e;

  state_e state, nextState;
  opcode_e opc;

  assign opc    = opcode_e'(stat.opcode);
  assign halted = (state == S_HALT);

  always_comb begin
    ctrl      = '0;
    ctrl.aluOp = ALU_PASS;
    nextState = state;
    unique case (state)
      S_INIT: begin
        ctrl.clr  = 1'b1;
        nextState = S_FETCH1;
      end
      S_FETCH1: begin
        ctrl.imemRd = 1'b1;
        nextState   = S_FETCH2;
      end
      S_FETCH2: begin
        ctrl.imemRd  = 1'b1;
        ctrl.fetchLo = 1'b1;
        ctrl.irHiLd  = 1'b1;
        nextState    = S_DECODE;
      end
      S_DECODE: begin
        ctrl.irLoLd = 1'b1;
        case (opc)
          OPC_LOAD, OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: nextState = S_DRD;
          OPC_STORE: nextState = S_DWR;
          OPC_BRZ:   nextState = stat.flagZ ? S_TAKEN : S_ADVANCE;
          OPC_BRN:   nextState = stat.flagN ? S_TAKEN : S_ADVANCE;
          OPC_JMP:   nextState = S_TAKEN;
          OPC_HALT:  nextState = S_HALT;
          default:   nextState = S_ADVANCE;
        endcase
      end
      S_DRD: begin
        ctrl.dmemRd = 1'b1;
        nextState   = S_DEXEC;
      end
      S_DEXEC: begin
        ctrl.accLd = 1'b1;
        ctrl.pcInc = 1'b1;
        case (opc)
          OPC_ADD: ctrl.aluOp = ALU_ADD;
          OPC_SUB: ctrl.aluOp = ALU_SUB;
          OPC_AND: ctrl.aluOp = ALU_AND;
          OPC_OR:  ctrl.aluOp = ALU_OR;
          default: ctrl.aluOp = ALU_PASS;
        endcase
        nextState = S_FETCH1;
      end
      S_DWR: begin
        ctrl.dmemWr = 1'b1;
        ctrl.pcInc  = 1'b1;
        nextState   = S_FETCH1;
      end
      S_TAKEN: begin
        ctrl.pcLd = 1'b1;
        nextState = S_FETCH1;
      end
      S_ADVANCE: begin
        ctrl.pcInc = 1'b1;
        nextState  = S_FETCH1;
      end
      S_HALT:  nextState = S_HALT;
      default: nextState = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_INIT;
    else     state <= nextState;
  end

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!ctrl.imemRd && !ctrl.dmemRd && !ctrl.dmemWr));

  p_decode_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE) |-> ($past(state) == S_FETCH2));

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.dmemWr |=> !ctrl.dmemWr);

  p_rw_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.dmemRd && ctrl.dmemWr));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int IBYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic               imemRd,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [IBYTE_W-1:0] imemRdata,
  output logic               dmemRd,
  output logic               dmemWr,
  output logic [ADDR_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWdata,
  input  logic [DATA_W-1:0]  dmemRdata,
  output logic               halted
);

  ctrl_t   ctrl;
  status_t stat;

  acc_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stat   (stat),
    .ctrl   (ctrl),
    .halted (halted)
  );

  acc_datapath #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .IBYTE_W (IBYTE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .imemRdata (imemRdata),
    .dmemRdata (dmemRdata),
    .imemAddr  (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .stat      (stat)
  );

  assign imemRd = ctrl.imemRd;
  assign dmemRd = ctrl.dmemRd;
  assign dmemWr = ctrl.dmemWr;

endmodule

// File: tb/acc_core_test.sv
module acc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemRd, dmemRd, dmemWr, halted;
  logic [15:0] imemAddr, dmemAddr, dmemWdata, dmemRdata;
  logic [7:0]  imemRdata;

  logic [7:0]  imem [0:255];
  logic [15:0] dmem [0:511];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // run results
  int          runCycles;
  int          wrCount;
  logic [15:0] haltAddr;
  logic [15:0] firstAddr [0:1];

  always #10 clk = ~clk;

  acc_core uut (
    .clk(clk), .rst(rst),
    .imemRd(imemRd), .imemAddr(imemAddr), .imemRdata(imemRdata),
    .dmemRd(dmemRd), .dmemWr(dmemWr), .dmemAddr(dmemAddr),
    .dmemWdata(dmemWdata), .dmemRdata(dmemRdata), .halted(halted)
  );

  // synchronous memory models
  always @(posedge clk) begin
    if (imemRd) imemRdata <= imem[imemAddr[7:0]];
    if (dmemRd) dmemRdata <= dmem[dmemAddr[8:0]];
    if (dmemWr) dmem[dmemAddr[8:0]] <= dmemWdata;
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) imem[i] = 8'hF0;  // HALT filler
    for (int i = 0; i < 512; i++) dmem[i] = 16'h0000;
  endtask

  task automatic put(input int addr, input logic [3:0] opc, input logic [11:0] opnd);
    imem[addr]     = {opc, opnd[11:8]};
    imem[addr + 1] = opnd[7:0];
  endtask

  task automatic runProg();
    int started;
    int nRd;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    runCycles = 0; wrCount = 0; started = 0; nRd = 0;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (dmemWr) wrCount++;
      if (halted) begin
        haltAddr = imemAddr;
        return;
      end
      if (imemRd) begin
        if (nRd < 2) firstAddr[nRd] = imemAddr;
        nRd++;
        started = 1;
      end
      if (started != 0) runCycles++;
    end
    check("R9 halt reached", 32'(halted), 32'd1);
  endtask

  // {opcode, a, b, expected}
  localparam logic [51:0] VEC [0:9] = '{
    {4'h3, 16'h0005, 16'h0003, 16'h0008},
    {4'h3, 16'hFFFF, 16'h0001, 16'h0000},
    {4'h3, 16'h7FFF, 16'h0001, 16'h8000},
    {4'h4, 16'h0005, 16'h0005, 16'h0000},
    {4'h4, 16'h0003, 16'h0005, 16'hFFFE},
    {4'h5, 16'hF0F0, 16'h0FF0, 16'h00F0},
    {4'h5, 16'hF0F0, 16'h0F0F, 16'h0000},
    {4'h6, 16'h8000, 16'h0001, 16'h8001},
    {4'h1, 16'h1234, 16'h8765, 16'h8765},
    {4'h1, 16'h8000, 16'h0042, 16'h0042}
  };

  initial begin
    // R1: strobes low during reset
    repeat (2) @(negedge clk);
    check("R1 reset strobes", {28'd0, imemRd, dmemRd, dmemWr, halted}, 32'd0);

    // Vector loop: LOAD a; OP b; STORE; BRZ C; BRN 10; HALT@A
    for (int v = 0; v < 10; v++) begin
      logic [3:0]  op;
      logic [15:0] a, b, e, expHalt;
      {op, a, b, e} = VEC[v];
      clearMem();
      put(16'h00, 4'h1, 12'h100);
      put(16'h02, op,   12'h101);
      put(16'h04, 4'h2, 12'h102);
      put(16'h06, 4'h7, 12'h00C);
      put(16'h08, 4'h8, 12'h010);
      dmem[9'h100] = a;
      dmem[9'h101] = b;
      dmem[9'h102] = 16'hDEAD;
      runProg();
      expHalt = (e == 16'h0) ? 16'h000C : (e[15] ? 16'h0010 : 16'h000A);
      // R3 R4 R5 result through STORE
      check("R5 R4 R3 result", 32'(dmem[9'h102]), 32'(e));
      // R7 R8 flags steer branches after STORE
      check("R7 R8 branch path", 32'(haltAddr), 32'(expHalt));
      check("R6 one write", wrCount, 1);
    end

    // R1 R2: reset clears acc and flags; fetch order
    clearMem();
    put(16'h00, 4'h2, 12'h102);
    put(16'h02, 4'h7, 12'h008);
    put(16'h04, 4'h8, 12'h008);
    dmem[9'h102] = 16'hAAAA;
    runProg();
    check("R1 acc cleared", 32'(dmem[9'h102]), 32'h0);
    check("R1 flags cleared", 32'(haltAddr), 32'h6);
    check("R1 first fetch addr", 32'(firstAddr[0]), 32'h0);
    check("R2 second fetch addr", 32'(firstAddr[1]), 32'h1);

    // R10 R7: NOP, undefined opcode, jump
    clearMem();
    put(16'h00, 4'h0, 12'h000);
    put(16'h02, 4'hA, 12'h123);
    put(16'h04, 4'h9, 12'h020);
    put(16'h06, 4'h2, 12'h000);
    put(16'h20, 4'hF, 12'h000);
    runProg();
    check("R10 no writes", wrCount, 0);
    check("R7 jump target", 32'(haltAddr), 32'h20);

    // R8: branch does not disturb Z
    clearMem();
    put(16'h00, 4'h1, 12'h100);
    put(16'h02, 4'h7, 12'h006);
    put(16'h06, 4'h7, 12'h00A);
    put(16'h08, 4'h2, 12'h102);
    runProg();
    check("R8 flags kept over branch", 32'(haltAddr), 32'hA);

    // R11: cycle count NOP, LOAD, STORE, BRZ not taken, HALT
    clearMem();
    put(16'h00, 4'h0, 12'h000);
    put(16'h02, 4'h1, 12'h100);
    put(16'h04, 4'h2, 12'h102);
    put(16'h06, 4'h7, 12'h00A);
    put(16'h0A, 4'h2, 12'h103);
    dmem[9'h100] = 16'h0005;
    runProg();
    check("R11 cycles to halt", runCycles, 20);
    check("R7 not taken halt addr", 32'(haltAddr), 32'h8);
    check("R6 stored value", 32'(dmem[9'h102]), 32'h5);

    // R9: halted stays and stays quiet
    begin
      int strobes = 0;
      int notHalted = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (imemRd || dmemRd || dmemWr) strobes++;
        if (!halted) notHalted++;
      end
      check("R9 no strobes while halted", strobes, 0);
      check("R9 halted sticky", notHalted, 0);
      check("R9 halt addr held", 32'(imemAddr), 32'h8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule